// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Control Registers

This block is the register file that host software uses to steer one bus-master disk DMA channel. Software loads the physical address of the descriptor table and picks the transfer direction first. It issues the command to the disk device. Only then does it set the start bit. The block passes start and direction straight to an external transfer engine. That engine walks the descriptors and moves the data. In return it reports three things: a level that says a transfer is in flight, and one-cycle pulses for an error and for an interrupt event.

The status byte mixes three kinds of bit. Bit 0 is a live copy of the engine's activity. The error and interrupt flags are sticky: hardware sets them, and software clears them by writing a 1. Two bits are plain software flags that record whether each of the two drives may use DMA. The interrupt flag also drives the interrupt line. A separate output marks a good completion: interrupt pending, no error, engine idle.

The register bus is a simple 32-bit bus with a byte address and byte-lane enables. Word 0 carries the command byte in lane 0 and the status byte in lane 2. Lanes 1 and 3 are reserved. Word 1, at byte address 4, is the descriptor table pointer.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After a clock edge with `rst` high, the command byte, status byte, descriptor pointer, `irq` and `xfer_good` are all zero.
- R2: A write to address 0 with `bus_be[0]` set loads command bit 0 into `xfer_start` and command bit 3 into `xfer_to_mem`, where 1 means device-to-memory. The other command bits always read 0.
- R3: Status bit 0 (`bus_rdata[16]` at address 0) equals the value `eng_active` had at the previous clock edge. Writes to it have no effect.
- R4: Status bit 1 (error) is set by an `eng_err_pulse` and stays set. A write at address 0 with `bus_be[2]` set and `bus_wdata[17]`=1 clears it. Writing 0 there leaves it unchanged.
- R5: Status bit 2 (interrupt) is set by an `eng_irq_pulse` and stays set. A write at address 0 with `bus_be[2]` set and `bus_wdata[18]`=1 clears it. Writing 0 there leaves it unchanged.
- R6: If a set pulse and a write-1 clear of the same sticky bit happen in the same cycle, the bit ends up set.
- R7: Status bits 5 and 6 (`bus_wdata[21]`, `bus_wdata[22]`) are read/write drive-capability flags, loaded by a write at address 0 with `bus_be[2]` set. Status bits 3, 4 and 7 read 0.
- R8: The descriptor pointer sits at address 4. Each byte lane is written only when its `bus_be` bit is set. Bits 1:0 always read 0. `desc_ptr` shows the stored value.
- R9: `irq` equals status bit 2.
- R10: `xfer_good` is 1 exactly when status bits 2:0 read 100b.
- R11: Reads at address 0 return {8'h00, status, 8'h00, command}. Lanes 1 and 3 ignore writes. Any address other than 0 or 4 reads zero and ignores writes. Nothing changes when `bus_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W (3) | Byte address of the 32-bit word |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_active | input | 1 | Engine reports a transfer in progress |
| eng_err_pulse | input | 1 | One-cycle engine error event |
| eng_irq_pulse | input | 1 | One-cycle engine interrupt event |
| xfer_start | output | 1 | Start/stop level to the engine |
| xfer_to_mem | output | 1 | Direction: 1 = device to memory |
| desc_ptr | output | 32 | Descriptor table pointer |
| irq | output | 1 | Interrupt request |
| xfer_good | output | 1 | Good-completion indication |

## Verification
The hardest case to reach from the ports is a set event that lands in the same cycle as a software clear of the same flag. The stimulus lines up an engine pulse with a write-1 to the status byte, for the interrupt bit and for the error bit, and checks that the bit survives. A second, single clear then removes it. Good completion needs the interrupt flag set while the error flag is clear and the engine is idle. The sequence therefore raises the interrupt flag while `eng_active` is high, drops the active level, and later injects an error to show the indication falling. A long random phase then mixes pulses, writes on every lane and address, and activity changes, with a behavioural model compared on every clock.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = REG_W / BYTE_W;

    // lane positions inside the control word at address 0
    localparam int CMD_LANE  = 0;
    localparam int STAT_LANE = 2;

    // bit positions inside the status byte (decoded by software)
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_CAP0 = 5;
    localparam int ST_CAP1 = 6;

    // bit positions inside the command byte
    localparam int CM_START = 0;
    localparam int CM_DIR   = 3;

    typedef struct packed {
        logic [3:0] rsvd_hi;
        logic       to_mem;
        logic [1:0] rsvd_mid;
        logic       start;
    } cmd_t;

    typedef struct packed {
        logic       rsvd7;
        logic [1:0] drv_cap;
        logic [1:0] rsvd43;
        logic       irq;
        logic       err;
        logic       act;
    } stat_t;

    function automatic logic completion_ok(stat_t s);
        return s.irq & ~s.err & ~s.act;
    endfunction

    function automatic logic [REG_W-1:0] ctl_word(cmd_t c, stat_t s);
        return {8'h00, s, 8'h00, c};
    endfunction

endpackage

// File: rtl/dmactl_cmd.sv
module dmactl_cmd
    import dmactl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic start_d,
    input  logic dir_d,
    output cmd_t cmd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_en) begin
            cmd_q.start  <= start_d;
            cmd_q.to_mem <= dir_d;
        end
    end

endmodule

// File: rtl/dmactl_stat.sv
module dmactl_stat
    import dmactl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       eng_active,
    input  logic       set_err,
    input  logic       set_irq,
    input  logic       clr_err,
    input  logic       clr_irq,
    input  logic       cap_wr,
    input  logic [1:0] cap_d,
    output stat_t      st_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.act <= eng_active;
            // a set event wins over a same-cycle clear
            st_q.err <= set_err | (st_q.err & ~clr_err);
            st_q.irq <= set_irq | (st_q.irq & ~clr_irq);
            if (cap_wr) begin
                st_q.drv_cap <= cap_d;
            end
        end
    end

endmodule

// File: rtl/dmactl_ptr.sv
module dmactl_ptr #(
    parameter int PTR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PTR_W/8-1:0] be,
    input  logic [PTR_W-1:2]   wdata,
    output logic [PTR_W-1:0]   ptr
);

    localparam int NLANE = PTR_W / 8;

    logic [PTR_W-1:2] ptr_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        if (g == 0) begin : g_low
            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q[7:2] <= '0;
                end else if (wr_en && be[0]) begin
                    ptr_q[7:2] <= wdata[7:2];
                end
            end
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q[g*8 +: 8] <= '0;
                end else if (wr_en && be[g]) begin
                    ptr_q[g*8 +: 8] <= wdata[g*8 +: 8];
                end
            end
        end
    end

    assign ptr = {ptr_q, 2'b00};

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dmactl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_active,
    input  logic              eng_err_pulse,
    input  logic              eng_irq_pulse,
    output logic              xfer_start,
    output logic              xfer_to_mem,
    output logic [31:0]       desc_ptr,
    output logic              irq,
    output logic              xfer_good
);

    localparam int SB = STAT_LANE * BYTE_W;
    localparam int CB = CMD_LANE * BYTE_W;

    logic  hit_ctl, hit_ptr;
    logic  cmd_wr, stat_wr;
    cmd_t  cmd_q;
    stat_t st_q;
    logic [7:0] st_byte;

    assign hit_ctl = (bus_addr == ADDR_W'(0));
    assign hit_ptr = (bus_addr == ADDR_W'(4));
    assign cmd_wr  = bus_wr & hit_ctl & bus_be[CMD_LANE];
    assign stat_wr = bus_wr & hit_ctl & bus_be[STAT_LANE];

    dmactl_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd_wr),
        .start_d (bus_wdata[CB + CM_START]),
        .dir_d   (bus_wdata[CB + CM_DIR]),
        .cmd_q   (cmd_q)
    );

    dmactl_stat u_stat (
        .clk        (clk),
        .rst        (rst),
        .eng_active (eng_active),
        .set_err    (eng_err_pulse),
        .set_irq    (eng_irq_pulse),
        .clr_err    (stat_wr & bus_wdata[SB + ST_ERR]),
        .clr_irq    (stat_wr & bus_wdata[SB + ST_IRQ]),
        .cap_wr     (stat_wr),
        .cap_d      (bus_wdata[SB + ST_CAP1 : SB + ST_CAP0]),
        .st_q       (st_q)
    );

    dmactl_ptr #(.PTR_W(REG_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr & hit_ptr),
        .be    (bus_be),
        .wdata (bus_wdata[REG_W-1:2]),
        .ptr   (desc_ptr)
    );

    always_comb begin
        if (hit_ctl)      bus_rdata = ctl_word(cmd_q, st_q);
        else if (hit_ptr) bus_rdata = desc_ptr;
        else              bus_rdata = '0;
    end

    assign st_byte     = st_q;
    assign xfer_start  = cmd_q.start;
    assign xfer_to_mem = cmd_q.to_mem;
    assign irq         = st_q.irq;
    assign xfer_good   = completion_ok(st_q);

endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              eng_active,
    input logic              eng_err_pulse,
    input logic              eng_irq_pulse,
    input logic [31:0]       desc_ptr,
    input logic              irq,
    input logic              xfer_good,
    input logic [7:0]        st_byte
);

    logic swclr_err, swclr_irq;
    assign swclr_err = bus_wr && (bus_addr == ADDR_W'(0)) && bus_be[2] && bus_wdata[17];
    assign swclr_irq = bus_wr && (bus_addr == ADDR_W'(0)) && bus_be[2] && bus_wdata[18];

    AST_ACT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        eng_active |=> st_byte[0]); // R3
    AST_ACT_DROPS: assert property (@(posedge clk) disable iff (rst)
        !eng_active |=> !st_byte[0]); // R3
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        eng_err_pulse |=> st_byte[1]); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_byte[1] && !swclr_err) |=> st_byte[1]); // R4
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (eng_irq_pulse && swclr_irq) |=> irq); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !swclr_irq) |=> irq); // R5
    AST_GOOD_PATTERN: assert property (@(posedge clk) disable iff (rst)
        xfer_good |-> (st_byte[2] && !st_byte[1] && !st_byte[0])); // R10
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        desc_ptr[1:0] == 2'b00); // R8

endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_dma_ctrl_regs.sv
`timescale 1ns/1ps
module test_dma_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_active = 1'b0, eng_err_pulse = 1'b0, eng_irq_pulse = 1'b0;
    logic        xfer_start, xfer_to_mem, irq, xfer_good;
    logic [31:0] desc_ptr;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    bit m_start, m_dir, m_act, m_err, m_irq;
    bit [1:0]  m_cap;
    bit [31:0] m_ptr;

    always #4 clk = ~clk;

    dma_ctrl_regs i_dma_ctrl_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_active(eng_active), .eng_err_pulse(eng_err_pulse),
        .eng_irq_pulse(eng_irq_pulse), .xfer_start(xfer_start),
        .xfer_to_mem(xfer_to_mem), .desc_ptr(desc_ptr), .irq(irq),
        .xfer_good(xfer_good)
    );

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_start = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0;
            m_cap = 0; m_ptr = 0;
        end else begin
            bit w0, w4, sclr_e, sclr_i;
            w0 = bus_wr && bus_addr == 3'd0;
            w4 = bus_wr && bus_addr == 3'd4;
            sclr_e = w0 && bus_be[2] && bus_wdata[17];
            sclr_i = w0 && bus_be[2] && bus_wdata[18];
            m_act = eng_active;
            if (eng_err_pulse) m_err = 1; else if (sclr_e) m_err = 0;
            if (eng_irq_pulse) m_irq = 1; else if (sclr_i) m_irq = 0;
            if (w0 && bus_be[2]) m_cap = bus_wdata[22:21];
            if (w0 && bus_be[0]) begin
                m_start = bus_wdata[0];
                m_dir   = bus_wdata[3];
            end
            if (w4) begin
                for (int k = 0; k < 4; k++)
                    if (bus_be[k]) m_ptr[k*8 +: 8] = bus_wdata[k*8 +: 8];
                m_ptr[1:0] = 2'b00;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // compare on every clock, mid-cycle
    always @(negedge clk) begin
        if (started && !done) begin
            logic [7:0]  s;
            logic [31:0] er;
            s = {1'b0, m_cap, 2'b00, m_irq, m_err, m_act};
            if (bus_addr == 3'd0)      er = {8'h00, s, 8'h00, 4'h0, m_dir, 2'b00, m_start};
            else if (bus_addr == 3'd4) er = m_ptr;
            else                       er = 32'h0;
            chk(rst ? "R1 rdata" : "R11 rdata", bus_rdata, er);
            chk("R2 xfer_start", {31'b0, xfer_start}, {31'b0, m_start});
            chk("R2 xfer_to_mem", {31'b0, xfer_to_mem}, {31'b0, m_dir});
            chk("R8 desc_ptr", desc_ptr, m_ptr);
            chk("R9 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R10 xfer_good", {31'b0, xfer_good}, {31'b0, m_irq & ~m_err & ~m_act});
        end
    end

    task automatic cyc(input bit wr, input logic [2:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input bit act, input bit ep, input bit ip);
        @(posedge clk);
        #2;
        bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
        eng_active = act; eng_err_pulse = ep; eng_irq_pulse = ip;
    endtask

    task automatic idle(input logic [2:0] a, input bit act);
        cyc(0, a, 4'h0, 32'h0, act, 0, 0);
    endtask

    task automatic point_check(input string tag, input logic [31:0] exp);
        @(negedge clk);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        point_check("R1 reset word0", 32'h0);
        #2 rst = 0;
        idle(3'd4, 0);
        point_check("R1 reset ptr", 32'h0);
        // R2: direction first, then start; upper command bits stay zero
        cyc(1, 3'd0, 4'h1, 32'h0000_0008, 0, 0, 0);
        cyc(1, 3'd0, 4'h1, 32'h0000_00FF, 0, 0, 0);
        idle(3'd0, 0);
        point_check("R2 cmd readback", 32'h0000_0009);
        cyc(1, 3'd0, 4'h1, 32'h0000_0000, 0, 0, 0);
        // R11: reserved lanes, no strobe, other address
        cyc(1, 3'd0, 4'hA, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(0, 3'd0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 3'd2, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
        idle(3'd0, 0);
        point_check("R11 ignored writes", 32'h0);
        // R3: active follows engine; write to bit0 has no effect
        cyc(1, 3'd0, 4'h4, 32'h0001_0000, 1, 0, 0);
        idle(3'd0, 1);
        point_check("R3 active set", 32'h0001_0000);
        // R10: interrupt while active is not good
        cyc(0, 3'd0, 4'h0, 0, 1, 0, 1);
        idle(3'd0, 0);
        idle(3'd0, 0);
        point_check("R10 good completion", 32'h0004_0000);
        // R5: writing zero does not clear
        cyc(1, 3'd0, 4'h4, 32'h0000_0000, 0, 0, 0);
        // R4 error makes it bad
        cyc(0, 3'd0, 4'h0, 0, 0, 1, 0);
        idle(3'd0, 0);
        point_check("R4 err sticky", 32'h0006_0000);
        // R4 clear error only
        cyc(1, 3'd0, 4'h4, 32'h0002_0000, 0, 0, 0);
        idle(3'd0, 0);
        point_check("R4 err cleared", 32'h0004_0000);
        // R6: set and clear together, interrupt survives
        cyc(1, 3'd0, 4'h4, 32'h0006_0000, 0, 0, 1);
        idle(3'd0, 0);
        point_check("R6 irq set wins", 32'h0004_0000);
        cyc(1, 3'd0, 4'h4, 32'h0002_0000, 0, 1, 0);
        idle(3'd0, 0);
        point_check("R6 err set wins", 32'h0006_0000);
        // R5 clear both with 0x06
        cyc(1, 3'd0, 4'h4, 32'h0006_0000, 0, 0, 0);
        idle(3'd0, 0);
        point_check("R5 both cleared", 32'h0);
        // R7: capability flags, reserved status bits zero
        cyc(1, 3'd0, 4'h4, 32'h00F9_0000, 0, 0, 0);
        idle(3'd0, 0);
        point_check("R7 cap flags", 32'h0060_0000);
        cyc(1, 3'd0, 4'h4, 32'h0020_0000, 0, 0, 0);
        idle(3'd0, 0);
        point_check("R7 cap drive0 only", 32'h0020_0000);
        // R8: pointer alignment and byte lanes
        cyc(1, 3'd4, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
        idle(3'd4, 0);
        point_check("R8 ptr aligned", 32'hFFFF_FFFC);
        cyc(1, 3'd4, 4'h5, 32'h1234_5677, 0, 0, 0);
        cyc(1, 3'd4, 4'h0, 32'h0000_0000, 0, 0, 0);
        idle(3'd4, 0);
        point_check("R8 ptr lanes", 32'hFF34_FF74);
        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] a;
            a = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd4 : 3'd0);
            cyc($urandom % 3 == 0, a, 4'($urandom), $urandom,
                $urandom % 2, $urandom % 5 == 0, $urandom % 4 == 0);
        end
        // R1 reset again mid-run
        @(posedge clk); #2 rst = 1;
        idle(3'd0, 1);
        @(posedge clk); #2 rst = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule